// File: doc/BRIEF.md
# Segment Address Translation Unit

This block converts a logical address into a 32-bit linear address. A logical address is a 16-bit segment selector plus a 32-bit offset. The selector names one entry in one of two register-held descriptor tables: a global table and a local table. Each entry holds a 32-bit base, a 32-bit limit and an 8-bit type byte. The unit checks each request in a fixed order: null selector, table bounds, access type, then segment limit. If every check passes, it adds the base to the offset. If any check fails, it returns a fault code in place of an address.

A requester presents the selector, the offset and an access kind (fetch, read or write) under a valid/ready handshake. One cycle later the unit returns the linear address and the fault code. A host loads descriptors through a simple single-cycle write port. The linear space stays 4 GiB however many segments are defined, because the sum is cut back to 32 bits.

Top module: `seg_xlate_unit`

## Requirements
- R1: A selector with index 0 and the table bit clear (bit 2 = 0) is null, whatever its two low bits hold, and returns fault code 1. Local index 0 (table bit set) is not null.
- R2: An index at or beyond the chosen table's entry count (global default 8, local default 16) returns fault code 2.
- R3: A fetch (kind 0) needs type 0x9A. A read (kind 1) needs type 0x9A or 0x92. A write (kind 2) needs type 0x92. Kind 3, type 0x89 and every other type return fault code 3.
- R4: An offset greater than the segment limit returns fault code 4. An offset equal to the limit passes.
- R5: On success the linear address is base plus offset, modulo 2^32. On any fault the linear address output is 0.
- R6: When several checks fail, the lowest non-zero code is reported (null 1, bounds 2, type 3, limit 4). Code 0 means success.
- R7: A request is accepted when req_valid and req_ready are both high. Its result appears with rsp_valid on the next cycle. While rsp_valid is high and rsp_ready is low, the result stays unchanged and req_ready is low.
- R8: A descriptor write in the same cycle as an accepted lookup of that entry leaves the lookup with the old descriptor. Later lookups see the new one.
- R9: After reset, rsp_valid is 0, req_ready is 1, and every descriptor is cleared to zero, so any in-bounds, non-null lookup returns fault code 3.
- R10: A flat descriptor (base 0, limit 0xFFFFFFFF) maps every offset, including 0xFFFFFFFF, to itself.
- R11: Selector bits [15:3] are the index, bit 2 selects the local table when set, and bits [1:0] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within segment |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 reserved |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_lin | output | 32 | Linear address, 0 on fault |
| rsp_fault | output | 3 | Fault code 0..4 |
| wr_en | input | 1 | Descriptor write strobe |
| wr_local | input | 1 | 1 writes local table, 0 global |
| wr_idx | input | 13 | Entry index to write |
| wr_base | input | 32 | Base to store |
| wr_limit | input | 32 | Limit to store |
| wr_type | input | 8 | Type byte to store |

## Verification
The translation path is driven with several kinds of segment. Flat code and data segments show the identity mapping at the extremes of the offset range. Offset segments show the addition, and a high-based segment shows the sum wrapping past 2^32. A short local segment is accessed at its limit and one past it, which separates a correct comparison from an off-by-one error. Other selectors combine several failures at once, such as a wrong type together with an offset over the limit, or a null selector with nonzero low bits; these show that the priority order holds and that the low selector bits are ignored. Directed cases cover backpressure holding the result, a write colliding with a lookup of the same entry, and empty tables after reset.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int SEL_W  = 16;
  localparam int IDX_W  = 13;
  localparam int ADDR_W = 32;
  localparam int TYPE_W = 8;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [TYPE_W-1:0] kind;
  } seg_desc_t;

  typedef enum logic [CODE_W-1:0] {
    FLT_NONE   = 3'd0,
    FLT_NULL   = 3'd1,
    FLT_BOUNDS = 3'd2,
    FLT_TYPE   = 3'd3,
    FLT_LIMIT  = 3'd4
  } seg_fault_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } seg_acc_e;

  localparam logic [TYPE_W-1:0] TY_CODE = 8'h9A;
  localparam logic [TYPE_W-1:0] TY_DATA = 8'h92;

  // index field of a selector
  function automatic logic [IDX_W-1:0] sel_index(input logic [SEL_W-1:0] s);
    return s[SEL_W-1:3];
  endfunction

  // table bit of a selector: 1 = local table
  function automatic logic sel_is_local(input logic [SEL_W-1:0] s);
    return s[2];
  endfunction

  // which access kinds a type byte permits
  function automatic logic type_permits(input seg_acc_e acc, input logic [TYPE_W-1:0] ty);
    case (acc)
      ACC_FETCH: return ty == TY_CODE;
      ACC_READ:  return (ty == TY_CODE) || (ty == TY_DATA);
      ACC_WRITE: return ty == TY_DATA;
      default:   return 1'b0;
    endcase
  endfunction

  // base plus offset, wrapped to the linear width
  function automatic logic [ADDR_W-1:0] lin_sum(input logic [ADDR_W-1:0] b,
                                                input logic [ADDR_W-1:0] o);
    return b + o;
  endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  seg_desc_t        wr_desc,
  input  logic [IDX_W-1:0] rd_idx,
  output seg_desc_t        rd_desc,
  output logic             rd_in_range
);

  localparam logic [IDX_W:0] DEPTH_X = (IDX_W+1)'(DEPTH);

  seg_desc_t entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        entry_q[g] <= wr_desc;
    end
  end

  assign rd_in_range = {1'b0, rd_idx} < DEPTH_X;

  always_comb begin
    rd_desc = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == IDX_W'(i)) rd_desc = entry_q[i];
  end

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_xlate_pkg::*;
(
  input  logic              null_hit,
  input  logic              bound_miss,
  input  seg_desc_t         desc,
  input  seg_acc_e          acc,
  input  logic [ADDR_W-1:0] offset,
  output seg_fault_e        fault,
  output logic [ADDR_W-1:0] lin,
  output logic              type_bad,
  output logic              over_limit
);

  assign type_bad   = !type_permits(acc, desc.kind);
  assign over_limit = offset > desc.limit;

  always_comb begin
    if (null_hit)        fault = FLT_NULL;
    else if (bound_miss) fault = FLT_BOUNDS;
    else if (type_bad)   fault = FLT_TYPE;
    else if (over_limit) fault = FLT_LIMIT;
    else                 fault = FLT_NONE;
  end

  assign lin = (fault == FLT_NONE) ? lin_sum(desc.base, offset) : '0;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int GLB_DEPTH = 8,
  parameter int LOC_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_lin,
  output logic [CODE_W-1:0] rsp_fault,
  input  logic              wr_en,
  input  logic              wr_local,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_limit,
  input  logic [TYPE_W-1:0] wr_type
);

  // named internal events
  logic              accept;
  logic [IDX_W-1:0]  sel_idx;
  logic              sel_loc;
  logic              null_hit;
  logic              bound_miss;
  logic              glb_in, loc_in;
  seg_desc_t         glb_desc, loc_desc, pick_desc, new_desc;
  seg_fault_e        chk_fault;
  logic [ADDR_W-1:0] chk_lin;
  logic              type_bad, over_limit;

  assign sel_idx  = sel_index(req_sel);
  assign sel_loc  = sel_is_local(req_sel);
  assign null_hit = !sel_loc && (sel_idx == '0);
  assign new_desc = '{base: wr_base, limit: wr_limit, kind: wr_type};

  seg_desc_table #(.DEPTH(GLB_DEPTH)) u_glb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && !wr_local), .wr_idx(wr_idx), .wr_desc(new_desc),
    .rd_idx(sel_idx), .rd_desc(glb_desc), .rd_in_range(glb_in)
  );

  seg_desc_table #(.DEPTH(LOC_DEPTH)) u_loc (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && wr_local), .wr_idx(wr_idx), .wr_desc(new_desc),
    .rd_idx(sel_idx), .rd_desc(loc_desc), .rd_in_range(loc_in)
  );

  assign pick_desc  = sel_loc ? loc_desc : glb_desc;
  assign bound_miss = sel_loc ? !loc_in : !glb_in;

  seg_access_check u_chk (
    .null_hit(null_hit), .bound_miss(bound_miss), .desc(pick_desc),
    .acc(seg_acc_e'(req_kind)), .offset(req_off),
    .fault(chk_fault), .lin(chk_lin),
    .type_bad(type_bad), .over_limit(over_limit)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_lin   <= '0;
      rsp_fault <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_lin   <= chk_lin;
      rsp_fault <= chk_fault;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R7: result held under backpressure
  a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_lin) && $stable(rsp_fault));

  // R7: accepted request yields a response next cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R1: null selector reported as code 1
  a_r1_null_fault: assert property (@(posedge clk) disable iff (!rst_n)
    accept && null_hit |=> rsp_fault == 3'd1);

  // R2: out-of-table index reported as code 2 when not null
  a_r2_bounds_fault: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !null_hit && bound_miss |=> rsp_fault == 3'd2);

  // R5: faulted responses carry no address
  a_r5_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 3'd0 |-> rsp_lin == '0);

  // R4: a clean result never exceeds the limit
  a_r4_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    accept && chk_fault == FLT_NONE |-> req_off <= pick_desc.limit);

  // R3: a type mismatch never passes as success
  a_r3_type_gate: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !null_hit && !bound_miss && type_bad |=> rsp_fault == 3'd3);

endmodule

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_lin;
  logic [2:0]  rsp_fault;
  logic        wr_en = 1'b0;
  logic        wr_local = 1'b0;
  logic [12:0] wr_idx = '0;
  logic [31:0] wr_base = '0;
  logic [31:0] wr_limit = '0;
  logic [7:0]  wr_type = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  seg_xlate_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_off(req_off), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_lin(rsp_lin), .rsp_fault(rsp_fault),
    .wr_en(wr_en), .wr_local(wr_local), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_type(wr_type)
  );

  // {sel, off, kind, fault, lin}
  localparam int NV = 20;
  localparam logic [84:0] VEC [NV] = '{
    {16'h0008, 32'h1234_5678, 2'd0, 3'd0, 32'h1234_5678}, // R10 flat code
    {16'h0010, 32'hFFFF_FFFF, 2'd2, 3'd0, 32'hFFFF_FFFF}, // R10 R4 flat top
    {16'h0000, 32'h0000_0000, 2'd1, 3'd1, 32'h0},         // R1 null
    {16'h0003, 32'h0000_0000, 2'd1, 3'd1, 32'h0},         // R1 R11 null with RPL
    {16'h0040, 32'h0000_0000, 2'd1, 3'd2, 32'h0},         // R2 global idx 8
    {16'h0084, 32'h0000_0000, 2'd1, 3'd2, 32'h0},         // R2 local idx 16
    {16'h0018, 32'h0000_0000, 2'd1, 3'd3, 32'h0},         // R3 task-state
    {16'h0010, 32'h0000_0000, 2'd0, 3'd3, 32'h0},         // R3 fetch data
    {16'h0008, 32'h0000_0000, 2'd2, 3'd3, 32'h0},         // R3 write code
    {16'h0008, 32'h0000_0005, 2'd1, 3'd0, 32'h0000_0005}, // R3 read code ok
    {16'h0004, 32'h0000_0FFF, 2'd2, 3'd0, 32'h0040_0FFF}, // R4 at limit, local 0 not null
    {16'h0004, 32'h0000_1000, 2'd2, 3'd4, 32'h0},         // R4 past limit
    {16'h0020, 32'h0001_8000, 2'd1, 3'd0, 32'h0000_8000}, // R5 wrap
    {16'h002F, 32'h0000_01FF, 2'd0, 3'd0, 32'h0100_01FF}, // R11 RPL 3
    {16'h002C, 32'h0000_0200, 2'd0, 3'd4, 32'h0},         // R4 code over limit
    {16'h002C, 32'h0000_0200, 2'd2, 3'd3, 32'h0},         // R6 type beats limit
    {16'h007C, 32'h0000_0010, 2'd1, 3'd0, 32'h0000_2010}, // R5 local 15
    {16'h0030, 32'h0000_0000, 2'd1, 3'd3, 32'h0},         // R9 empty global
    {16'h0044, 32'h0000_0000, 2'd1, 3'd3, 32'h0},         // R9 empty local
    {16'h0010, 32'h0000_0000, 2'd3, 3'd3, 32'h0}          // R3 reserved kind
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic loc, input int idx, input logic [31:0] b,
                          input logic [31:0] l, input logic [7:0] t);
    @(negedge clk);
    wr_en = 1'b1; wr_local = loc; wr_idx = 13'(idx);
    wr_base = b; wr_limit = l; wr_type = t;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [15:0] s, input logic [31:0] o, input logic [1:0] k);
    @(negedge clk);
    req_valid = 1'b1; req_sel = s; req_off = o; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R9 req_ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;

    put_desc(1'b0, 1, 32'h0, 32'hFFFF_FFFF, 8'h9A);
    put_desc(1'b0, 2, 32'h0, 32'hFFFF_FFFF, 8'h92);
    put_desc(1'b0, 3, 32'h0000_1000, 32'h67, 8'h89);
    put_desc(1'b0, 4, 32'hFFFF_0000, 32'h0002_0000, 8'h92);
    put_desc(1'b1, 0, 32'h0040_0000, 32'h0000_0FFF, 8'h92);
    put_desc(1'b1, 5, 32'h0100_0000, 32'h0000_01FF, 8'h9A);
    put_desc(1'b1, 15, 32'h0000_2000, 32'h10, 8'h92);

    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][84:69], VEC[i][68:37], VEC[i][36:35]);
      check($sformatf("R7 valid vec %0d", i), 64'(rsp_valid), 64'd1);
      check($sformatf("R6 fault vec %0d", i), 64'(rsp_fault), 64'(VEC[i][34:32]));
      check($sformatf("R5 lin vec %0d", i), 64'(rsp_lin), 64'(VEC[i][31:0]));
    end

    // R7 backpressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_sel = 16'h007C; req_off = 32'h4; req_kind = 2'd1;
    @(negedge clk);
    req_sel = 16'h0008; req_off = 32'h99; req_kind = 2'd0;
    for (int c = 0; c < 3; c++) begin
      check("R7 held valid", 64'(rsp_valid), 64'd1);
      check("R7 held lin", 64'(rsp_lin), 64'h2004);
      check("R7 ready low", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 second result", 64'(rsp_lin), 64'h99);
    @(negedge clk);
    check("R7 drained", 64'(rsp_valid), 64'd0);

    // R8 write collides with lookup of the same entry
    @(negedge clk);
    wr_en = 1'b1; wr_local = 1'b1; wr_idx = 13'd15;
    wr_base = 32'h0000_3000; wr_limit = 32'h10; wr_type = 8'h92;
    req_valid = 1'b1; req_sel = 16'h007C; req_off = 32'h0; req_kind = 2'd1;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R8 old value", 64'(rsp_lin), 64'h2000);
    lookup(16'h007C, 32'h0, 2'd1);
    check("R8 new value", 64'(rsp_lin), 64'h3000);

    // R9 tables cleared by reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 valid after reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    lookup(16'h0008, 32'h0, 2'd0);
    check("R9 cleared global", 64'(rsp_fault), 64'd3);
    lookup(16'h0004, 32'h0, 2'd1);
    check("R9 cleared local", 64'(rsp_fault), 64'd3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule